// File: doc/BRIEF.md
# Serial-Loaded Dual Wiper Register Controller

This block is the logic core of a two-channel, 256-step programmable resistor. A host writes it over a three-wire serial link: a serial clock, an active-low select and a data input. Each transfer is a 10-bit word made of two address bits and one 8-bit wiper code. The block keeps one code per channel and drives the per-channel terminal-control flags that an analog resistor ladder would use. A serial output makes it possible to chain several devices on one data line. That output is modelled as the pull-down enable of an open-drain driver.

All three serial inputs are resynchronised into the system clock domain. Edges of the serial clock and of the select line are detected there, so every piece of state changes on the system clock. When select goes high, the last ten bits shifted in are decoded. Their data byte is written to the channel that the low address bit names. An active-low shutdown input opens both A terminals, shorts both wipers to B and releases the serial output. The stored codes are left untouched, and the serial interface keeps working during shutdown.

Top module: `wiper_ctrl_top`

## Requirements
- R1: A word is ten bits sent first-to-last as A1, A0, D7, D6, D5, D4, D3, D2, D1, D0. After the word is shifted in, A1 sits in shift-register bit 9, A0 in bit 8 and D7..D0 in bits 7..0.
- R2: While ser_sel_n is low, each rising edge of ser_clk shifts the value on ser_din into the LSB of the 10-bit shift register.
- R3: sdo_pull_dn is 1 exactly when shdn_n is high and the oldest of the ten held bits (bit 9, the bit entered ten shifts earlier) is 0. Bits shifted past it leave the register.
- R4: On a rising edge of ser_sel_n, the data byte of the last ten bits shifted in is written to the addressed channel. Bits sent before those ten are discarded.
- R5: A wiper code changes only as a result of a select rising edge.
- R6: Only A0 is decoded: A0=0 selects channel 0 (wiper_codes[7:0]) and A0=1 selects channel 1 (wiper_codes[15:8]). A1 is ignored. One word updates exactly one channel.
- R7: After reset, both wiper codes are 0x80 and the shift register holds all zeros, so sdo_pull_dn is 1 while shdn_n is high.
- R8: While shdn_n is low, term_a_open and wiper_to_b are all ones and sdo_pull_dn is 0. While shdn_n is high, the flags are all zero.
- R9: Shutdown leaves the stored codes unchanged. Words sent during shutdown are still shifted and loaded, and when shutdown is released the channels show the stored codes.
- R10: ser_clk edges while ser_sel_n is high leave the shift register unchanged.
- R11: A load becomes visible on wiper_codes within four system clocks after ser_sel_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on preset) |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_sel_n | input | 1 | Active-low serial select; its rising edge loads |
| ser_din | input | 1 | Serial data input, first bit A1 |
| shdn_n | input | 1 | Active-low shutdown |
| wiper_codes | output | 16 | Channel 1 code in [15:8], channel 0 code in [7:0] |
| term_a_open | output | 2 | Per channel: A terminal open |
| wiper_to_b | output | 2 | Per channel: wiper shorted to B |
| sdo_pull_dn | output | 1 | Pull-down enable of the open-drain serial output |

## Verification
A wrong bit in the shift register shows up on sdo_pull_dn once it reaches the oldest position, which takes up to ten serial clocks. It also shows up in a wiper code at the next select rise. The bench therefore compares sdo_pull_dn after every shift and both codes after every load, against a ten-bit model. A decode fault or a stray write shows up at the very next load as a wrong or extra changed channel. A fault in the shutdown gating is visible on the flags at once, and is visible on the codes after release.

// File: rtl/wpot_pkg.sv
// Shared constants and types for the dual wiper controller.
// Assumes: one system clock domain; all serial inputs asynchronous to it.
package wpot_pkg;
    localparam int DEF_NUM_CH  = 2;
    localparam int DEF_CODE_W  = 8;
    localparam int DEF_ADDR_W  = 2;
    localparam int DEF_SYNC    = 2;

    // Per-cycle serial events derived from the synchronised inputs
    typedef struct packed {
        logic shift_en;  // serial clock rose while selected
        logic load_en;   // select rose
        logic din;       // synchronised data bit
        logic sel_idle;  // synchronised select is high
    } ser_evt_t;
endpackage

// File: rtl/wpot_sync.sv
// Multi-bit flop-chain synchroniser with a per-bit reset value.
// Assumes: STAGES >= 2; each bit is an independent level signal.
module wpot_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the asynchronous inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wpot_front.sv
// Serial front end: synchronises clock, select and data, and detects
// serial-clock and select rising edges in the system clock domain.
// Assumes: each serial level lasts at least two system clocks.
module wpot_front
    import wpot_pkg::*;
#(
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ser_clk,
    input  logic     ser_sel_n,
    input  logic     ser_din,
    output ser_evt_t evt
);
    // bit order: {clock, select, data}; select idles high
    localparam logic [2:0] SYNC_RST = 3'b010;

    logic [2:0] sync_q;
    logic       sclk_s, sel_s, din_s;
    logic       sclk_prev, sel_prev;

    wpot_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({ser_clk, ser_sel_n, ser_din}),
        .q_sync (sync_q)
    );

    assign {sclk_s, sel_s, din_s} = sync_q;

    // Remember the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            sel_prev  <= 1'b1;
        end else begin
            sclk_prev <= sclk_s;
            sel_prev  <= sel_s;
        end
    end

    // Form the per-cycle event record
    always_comb begin
        evt.shift_en = sclk_s & ~sclk_prev & ~sel_s;
        evt.load_en  = sel_s & ~sel_prev;
        evt.din      = din_s;
        evt.sel_idle = sel_s;
    end
endmodule

// File: rtl/wpot_shreg.sv
// Serial-in shift register; its MSB is the daisy-chain output bit.
// Assumes: shift_en is a single-cycle strobe.
module wpot_shreg #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              ser_out
);
    // Shift one bit in at the LSB on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], din};
    end

    assign ser_out = word[WORD_W-1];
endmodule

// File: rtl/wpot_bank.sv
// Wiper code latches with address decode; one channel per load.
// Assumes: NUM_CH >= 2 and is a power of two; only the low index bits
// of the address field take part in the decode.
module wpot_bank #(
    parameter int               NUM_CH = 2,
    parameter int               CODE_W = 8,
    parameter int               IDX_W  = 1,
    parameter logic [CODE_W-1:0] PRESET = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic [IDX_W+CODE_W-1:0]  dec_word,
    output logic [NUM_CH*CODE_W-1:0] codes
);
    logic [IDX_W-1:0]  ch_idx;
    logic [CODE_W-1:0] new_code;

    assign ch_idx   = dec_word[CODE_W +: IDX_W];
    assign new_code = dec_word[CODE_W-1:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Load this channel's code when the address selects it
        always_ff @(posedge clk) begin
            if (!rst_n)
                codes[g*CODE_W +: CODE_W] <= PRESET;
            else if (load_en && (ch_idx == IDX_W'(g)))
                codes[g*CODE_W +: CODE_W] <= new_code;
        end
    end
endmodule

// File: rtl/wiper_ctrl_top.sv
// Dual wiper register controller: serial front end, word shift register,
// wiper latches, and shutdown gating of terminal flags and serial output.
// Assumes: shdn_n acts immediately on the outputs; latches are unaffected.
module wiper_ctrl_top
    import wpot_pkg::*;
#(
    parameter int                NUM_CH      = DEF_NUM_CH,
    parameter int                CODE_W      = DEF_CODE_W,
    parameter int                ADDR_W      = DEF_ADDR_W,
    parameter int                SYNC_STAGES = DEF_SYNC,
    parameter logic [CODE_W-1:0] PRESET      = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_sel_n,
    input  logic                     ser_din,
    input  logic                     shdn_n,
    output logic [NUM_CH*CODE_W-1:0] wiper_codes,
    output logic [NUM_CH-1:0]        term_a_open,
    output logic [NUM_CH-1:0]        wiper_to_b,
    output logic                     sdo_pull_dn
);
    localparam int WORD_W = ADDR_W + CODE_W;
    localparam int IDX_W  = $clog2(NUM_CH);

    ser_evt_t          evt;
    logic [WORD_W-1:0] sr_word;
    logic              ser_out;

    wpot_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_sel_n(ser_sel_n),
        .ser_din  (ser_din),
        .evt      (evt)
    );

    wpot_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(evt.shift_en),
        .din     (evt.din),
        .word    (sr_word),
        .ser_out (ser_out)
    );

    wpot_bank #(
        .NUM_CH(NUM_CH),
        .CODE_W(CODE_W),
        .IDX_W (IDX_W),
        .PRESET(PRESET)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (evt.load_en),
        .dec_word(sr_word[IDX_W+CODE_W-1:0]),
        .codes   (wiper_codes)
    );

    // Shutdown opens every A terminal, shorts every wiper to B, and
    // releases the open-drain output
    always_comb begin
        term_a_open = {NUM_CH{~shdn_n}};
        wiper_to_b  = {NUM_CH{~shdn_n}};
        sdo_pull_dn = ~ser_out & shdn_n;
    end
endmodule

// File: rtl/wpot_chk.sv
// Property checker for wiper_ctrl_top, attached by bind.
// Assumes: internal event and shift-register signals are bound in.
module wpot_chk #(
    parameter int                NUM_CH = 2,
    parameter int                CODE_W = 8,
    parameter int                WORD_W = 10,
    parameter logic [CODE_W-1:0] PRESET = 8'h80
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     shdn_n,
    input logic                     load_en,
    input logic                     sel_idle,
    input logic [WORD_W-1:0]        sr_word,
    input logic [NUM_CH*CODE_W-1:0] codes,
    input logic [NUM_CH-1:0]        a_open,
    input logic [NUM_CH-1:0]        w_to_b,
    input logic                     pull_dn
);
    logic [NUM_CH*CODE_W-1:0] codes_q;
    logic [NUM_CH-1:0]        chg;

    // Previous codes, for per-channel change detection
    always_ff @(posedge clk) begin
        if (!rst_n) codes_q <= {NUM_CH{PRESET}};
        else        codes_q <= codes;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chg
        assign chg[g] = |(codes[g*CODE_W +: CODE_W] ^ codes_q[g*CODE_W +: CODE_W]);
    end

    // R5
    codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(codes));

    // R6
    one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    // R8
    shdn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> ((&a_open) && (&w_to_b) && !pull_dn));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idle |=> $stable(sr_word));
endmodule

bind wiper_ctrl_top wpot_chk #(
    .NUM_CH(NUM_CH),
    .CODE_W(CODE_W),
    .WORD_W(WORD_W),
    .PRESET(PRESET)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .shdn_n  (shdn_n),
    .load_en (evt.load_en),
    .sel_idle(evt.sel_idle),
    .sr_word (sr_word),
    .codes   (wiper_codes),
    .a_open  (term_a_open),
    .w_to_b  (wiper_to_b),
    .pull_dn (sdo_pull_dn)
);

// File: tb/tb_wiper_ctrl_top.sv
module tb_wiper_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_sel_n = 1'b1;
    logic        ser_din = 1'b0;
    logic        shdn_n = 1'b1;
    logic [15:0] wiper_codes;
    logic [1:0]  term_a_open;
    logic [1:0]  wiper_to_b;
    logic        sdo_pull_dn;

    int total = 0;
    int bad   = 0;

    logic [9:0] msr;       // model shift register
    logic [7:0] mcode [2]; // model wiper codes

    always #4 clk = ~clk;

    wiper_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .shdn_n(shdn_n), .wiper_codes(wiper_codes),
        .term_a_open(term_a_open), .wiper_to_b(wiper_to_b),
        .sdo_pull_dn(sdo_pull_dn)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_pull(input logic [9:0] sr, input logic sd);
        return sd & ~sr[9];
    endfunction

    // one serial clock period; R2/R3 checked after every shift
    task automatic clk_bit(input logic b);
        ser_clk = 1'b0;
        ser_din = b;
        tick(4);
        ser_clk = 1'b1;
        tick(4);
        if (!ser_sel_n) msr = {msr[8:0], b};
        chk("R3 pull_dn", {31'd0, sdo_pull_dn}, {31'd0, exp_pull(msr, shdn_n)});
    endtask

    task automatic select_low;
        ser_sel_n = 1'b0;
        tick(4);
    endtask

    // raise select and check both channels after the load (R4/R11)
    task automatic select_high(input string tag);
        ser_sel_n = 1'b1;
        mcode[msr[8]] = msr[7:0];
        tick(4);
        chk(tag, {16'd0, wiper_codes}, {16'd0, mcode[1], mcode[0]});
        ser_clk = 1'b0;
        tick(2);
    endtask

    task automatic send(input logic [31:0] bits, input int n, input string tag);
        select_low();
        for (int i = n - 1; i >= 0; i--) clk_bit(bits[i]);
        select_high(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        msr = '0;
        mcode[0] = 8'h80;
        mcode[1] = 8'h80;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R7: reset state
        chk("R7 codes", {16'd0, wiper_codes}, 32'h8080);
        chk("R7 pull_dn", {31'd0, sdo_pull_dn}, 32'd1);
        chk("R8 flags off", {28'd0, term_a_open, wiper_to_b}, 32'd0);

        // R1/R6: A0=0 selects channel 0, A0=1 channel 1
        send({22'd0, 2'b00, 8'h00}, 10, "R6 ch0 zero");
        send({22'd0, 2'b01, 8'hFF}, 10, "R6 ch1 full");
        send({22'd0, 2'b10, 8'h3C}, 10, "R6 A1 ignored ch0");
        send({22'd0, 2'b11, 8'hA5}, 10, "R1 A1 ignored ch1");

        // R4: extra leading bits discarded
        send({18'd0, 4'b1011, 2'b00, 8'h5A}, 14, "R4 extra bits");

        // R10: clocks with select high do nothing
        clk_bit(1'b1);
        clk_bit(1'b1);
        clk_bit(1'b0);
        chk("R10 sr idle", {31'd0, sdo_pull_dn}, {31'd0, exp_pull(msr, shdn_n)});
        send({22'd0, 2'b01, 8'h11}, 10, "R10 load after idle clocks");

        // R8/R9: shutdown gating, load during shutdown, resume
        shdn_n = 1'b0;
        tick(1);
        chk("R8 a_open", {30'd0, term_a_open}, 32'd3);
        chk("R8 w_to_b", {30'd0, wiper_to_b}, 32'd3);
        chk("R8 pull_dn off", {31'd0, sdo_pull_dn}, 32'd0);
        chk("R9 codes kept", {16'd0, wiper_codes}, {16'd0, mcode[1], mcode[0]});
        send({22'd0, 2'b00, 8'hC3}, 10, "R9 load in shutdown");
        shdn_n = 1'b1;
        tick(1);
        chk("R9 resume codes", {16'd0, wiper_codes}, {16'd0, mcode[1], mcode[0]});
        chk("R8 flags released", {28'd0, term_a_open, wiper_to_b}, 32'd0);

        // R5: select toggle with no new bits reloads same word
        send(32'd0, 0, "R5 empty frame");

        // random words, random lengths, random shutdown
        for (int k = 0; k < 40; k++) begin
            int n;
            n = 10 + int'($urandom % 6);
            shdn_n = ($urandom % 4) != 0;
            send($urandom, n, "R4 random word");
        end
        shdn_n = 1'b1;
        tick(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule